// File: doc/BRIEF.md
# Digitally Trimmed Seconds Prescaler

This block turns a 32.768 kHz clock-enable stream into a one-second tick whose average rate can be pulled by a signed 3-bit trim code. A divide counter advances once per enable and emits a single-cycle tick each time its value reaches the divide ratio. To correct for crystal error, a scheduler occasionally makes one enable advance the counter by two (the tick arrives early) or by zero (it arrives late).

Corrections are counted over a correction window of a fixed number of enables. With the defaults the window is 1,000,000 enables, about 30.5 seconds. Each trim step gives 20 corrections per window, so a step is 20 ppm and the range is three steps either way (±60 ppm). Inside a window the corrections are spread evenly by an accumulator. This keeps the schedule fully deterministic. The trim code is only sampled when a window closes, so a window never mixes two rates.

Top module: `sec_prescaler_trim`

## Requirements
- R1: While reset is asserted, and at its release, `tick_1s` is 0, the divide count is 0, the window position and accumulator are 0, and the active trim is "no correction".
- R2: Trim code encoding: bit 2 is the sign (0 = add counts, tick runs faster; 1 = skip counts, tick runs slower) and bits 1:0 are the magnitude in steps (0 to 3). Codes 3'b000 and 3'b100 both apply no correction.
- R3: With no correction active, every enable advances the count by one, so a tick follows every DIV enables.
- R4: `tick_1s` is high for exactly one clock. It is high in the cycle after the enable whose advance brings the count to DIV or beyond. The count then keeps the excess (count + advance − DIV).
- R5: A cycle with `en_32k` low changes no state and produces no tick.
- R6: Over each window of WIN_LEN enables, a magnitude m applies exactly m × STEP_CNT corrections.
- R7: Schedule: an accumulator starts at 0 in each window. On each enable it adds n = m × STEP_CNT. When the sum reaches WIN_LEN, that enable is corrected and WIN_LEN is subtracted from the sum.
- R8: A corrected enable advances the count by 2 when the sign is 0 and by 0 when the sign is 1.
- R9: The trim code is sampled only on the enable that closes a window (window position WIN_LEN−1) and governs the enables from the next one onward. Values held at other times have no effect.
- R10: The first window after reset applies no correction, whatever the trim input is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_32k | input | 1 | Single-cycle enable at the 32.768 kHz reference rate |
| trim_code | input | 3 | Signed trim: bit 2 sign, bits 1:0 magnitude |
| tick_1s | output | 1 | One-cycle pulse per corrected second |

## Verification
The bench walks through successive windows with reduced parameters. In each window it changes the trim code partway through, and in one window it changes the code and reverts it before the boundary. A design that sampled the code at any time other than the window close would put corrections into the wrong window and shift individual tick positions.

Windows with sparse enables expose a design that advances or ticks on idle cycles. The add windows push the count past DIV by one, which exposes a wrap that drops the excess. Codes 3'b100 and the ±3 extremes expose a faulty sign or magnitude decode. After every window the bench also compares the running tick total with the arithmetic sum of the window advances. This catches a miscounted schedule even when the per-cycle positions happen to match.

// File: rtl/sec_trim_pkg.sv
package sec_trim_pkg;

    // Signed trim setting: slow = skip counts, mag = number of steps
    typedef struct packed {
        logic       slow;
        logic [1:0] mag;
    } trim_t;

endpackage

// File: rtl/trim_decode.sv
module trim_decode
    import sec_trim_pkg::*;
#(
    parameter int STEP_CNT = 20,
    parameter int NW       = 8
) (
    input  trim_t            trim,
    output logic             slow,
    output logic [NW-1:0]    n_corr
);

    // corrections per window = magnitude x step size; sign passes through
    always_comb begin
        slow   = trim.slow;
        n_corr = NW'(STEP_CNT) * NW'(trim.mag);
    end

endmodule

// File: rtl/corr_sched.sv
module corr_sched
    import sec_trim_pkg::*;
#(
    parameter int WIN_LEN  = 1000000,
    parameter int STEP_CNT = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic [2:0] trim_code,
    output logic       corr_add,
    output logic       corr_skip
);

    localparam int WW = $clog2(WIN_LEN);
    localparam int AW = $clog2(2 * WIN_LEN) + 1;
    localparam logic [WW-1:0] WIN_LAST = WW'(WIN_LEN - 1);
    localparam logic [AW-1:0] WIN_A    = AW'(WIN_LEN);

    typedef struct packed {
        logic [WW-1:0] win;
        logic [AW-1:0] acc;
        trim_t         act;
    } sched_t;

    sched_t st_d, st_q;

    logic          act_slow;
    logic [AW-1:0] n_corr;
    logic [AW-1:0] sum;
    logic          fire;
    logic          win_end;

    trim_decode #(.STEP_CNT(STEP_CNT), .NW(AW)) u_dec (
        .trim   (st_q.act),
        .slow   (act_slow),
        .n_corr (n_corr)
    );

    always_comb begin
        st_d    = st_q;
        sum     = st_q.acc + n_corr;
        fire    = en && (sum >= WIN_A);
        win_end = en && (st_q.win == WIN_LAST);
        if (en) begin
            st_d.acc = fire ? (sum - WIN_A) : sum;
            if (win_end) begin
                st_d.win = '0;
                st_d.act = trim_t'(trim_code);
            end else begin
                st_d.win = st_q.win + 1'b1;
            end
        end
        corr_add  = fire && !act_slow;
        corr_skip = fire &&  act_slow;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_ACC_CLEAR_AT_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
        (en && st_q.win == WIN_LAST) |=> (st_q.acc == '0)); // R7

    AST_TRIM_HELD_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.act) |-> $past(en && st_q.win == WIN_LAST)); // R9

    AST_NO_CORR_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (corr_add || corr_skip) |-> (st_q.act.mag != 2'd0)); // R2

    AST_ACC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.acc < WIN_A); // R7

endmodule

// File: rtl/div_core.sv
module div_core #(
    parameter int DIV = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic corr_add,
    input  logic corr_skip,
    output logic tick
);

    localparam int CW = $clog2(DIV);
    localparam logic [CW:0] DIV_W = (CW+1)'(DIV);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          tick;
    } div_t;

    div_t st_d, st_q;
    logic [1:0] adv;
    logic [CW:0] sum;

    always_comb begin
        st_d = st_q;
        if (!en)            adv = 2'd0;
        else if (corr_skip) adv = 2'd0;
        else if (corr_add)  adv = 2'd2;
        else                adv = 2'd1;
        sum = {1'b0, st_q.cnt} + (CW+1)'(adv);
        if (sum >= DIV_W) begin
            st_d.tick = 1'b1;
            st_d.cnt  = CW'(sum - DIV_W);
        end else begin
            st_d.tick = 1'b0;
            st_d.cnt  = CW'(sum);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick = st_q.tick;

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, st_q.cnt} < DIV_W); // R4

    AST_TICK_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.tick |-> $past(en)); // R5

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(st_q.cnt) && !st_q.tick)); // R5

endmodule

// File: rtl/sec_prescaler_trim.sv
module sec_prescaler_trim #(
    parameter int DIV      = 32768,
    parameter int WIN_LEN  = 1000000,
    parameter int STEP_CNT = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_32k,
    input  logic [2:0] trim_code,
    output logic       tick_1s
);

    logic corr_add;
    logic corr_skip;

    corr_sched #(.WIN_LEN(WIN_LEN), .STEP_CNT(STEP_CNT)) u_sched (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en_32k),
        .trim_code (trim_code),
        .corr_add  (corr_add),
        .corr_skip (corr_skip)
    );

    div_core #(.DIV(DIV)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en_32k),
        .corr_add  (corr_add),
        .corr_skip (corr_skip),
        .tick      (tick_1s)
    );

    AST_CORR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(corr_add && corr_skip)); // R8

    AST_CORR_ON_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (corr_add || corr_skip) |-> en_32k); // R5

endmodule

// File: tb/sec_prescaler_trim_test.sv
module sec_prescaler_trim_test;

    localparam int DIV  = 8;
    localparam int WIN  = 40;
    localparam int STEP = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [2:0] trim = 3'b000;
    logic       tick;

    always #2 clk = ~clk;

    sec_prescaler_trim #(.DIV(DIV), .WIN_LEN(WIN), .STEP_CNT(STEP)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_32k    (en),
        .trim_code (trim),
        .tick_1s   (tick)
    );

    int    checks = 0;
    int    fails = 0;
    int    act_ticks = 0;
    bit    done = 1'b0;
    bit    exp_q[$];
    string req_q[$];
    string cur_req = "R1";

    // reference model state, built from the requirement text
    int m_cnt = 0, m_win = 0, m_acc = 0, m_n = 0;
    bit m_slow = 1'b0;
    int cum_adv = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor: compare tick one step after each driven cycle
    always @(posedge clk) begin
        bit    e;
        string r;
        #1;
        if (tick === 1'b1) act_ticks++;
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            r = req_q.pop_front();
            chk(tick === e, r, int'(tick), int'(e));
        end
    end

    // driver: one cycle, pushing the expected tick for it
    task automatic step(input bit e);
        bit exp_t;
        int s;
        int adv;
        @(negedge clk);
        en = e;
        exp_t = 1'b0;
        if (e) begin
            s = m_acc + m_n;                        // R7 accumulator
            adv = 1;
            if (s >= WIN) begin
                s -= WIN;
                adv = m_slow ? 0 : 2;               // R8
            end
            m_acc = s;
            m_cnt += adv;
            if (m_cnt >= DIV) begin                 // R4 keep excess
                exp_t = 1'b1;
                m_cnt -= DIV;
            end
            if (m_win == WIN - 1) begin             // R9 sample at close
                m_win  = 0;
                m_n    = int'(trim[1:0]) * STEP;
                m_slow = trim[2];
            end else begin
                m_win++;
            end
        end
        exp_q.push_back(exp_t);
        req_q.push_back(cur_req);
    endtask

    // one window of WIN enables; trim written at positions 10 and 30
    task automatic window(input logic [2:0] ca, input logic [2:0] cb,
                          input bit gap, input int adv, input string tag);
        cur_req = tag;
        for (int i = 0; i < WIN; i++) begin
            if (i == 10) trim = ca;
            if (i == 30) trim = cb;
            step(1'b1);
            if (gap) step(1'b0);
        end
        step(1'b0);
        cum_adv += adv;
        // R6: running tick total equals floor of summed advances
        chk(act_ticks == cum_adv / DIV, "R6 window total", act_ticks, cum_adv / DIV);
    endtask

    initial begin
        trim = 3'b001;
        repeat (4) @(negedge clk);
        chk(tick === 1'b0, "R1 tick in reset", int'(tick), 0);
        chk(act_ticks == 0, "R1 no ticks in reset", act_ticks, 0);
        rst_n = 1'b1;
        cur_req = "R1";
        step(1'b0);
        step(1'b0);
        window(3'b001, 3'b001, 1'b0, 40, "R10 R3");
        window(3'b111, 3'b111, 1'b0, 44, "R8 R7 R4 add");
        window(3'b100, 3'b100, 1'b0, 28, "R8 R7 R9 skip");
        window(3'b011, 3'b011, 1'b1, 40, "R2 R5 zero-neg");
        window(3'b101, 3'b101, 1'b0, 52, "R7 R4 add3");
        window(3'b000, 3'b000, 1'b1, 36, "R8 R5 skip1");
        window(3'b011, 3'b000, 1'b0, 40, "R2 R3 zero");
        window(3'b000, 3'b000, 1'b0, 40, "R9 reverted");
        repeat (3) step(1'b0);
        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R4 scoreboard drained", exp_q.size(), 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule